// File: doc/BRIEF.md
# Registered Tri-Port Bus Exchanger

This block moves 12-bit words between one A port and two B ports (B1 and B2). Four holding registers, each with its own active-low load strobe, carry data in each direction: A to B1, A to B2, B1 to A and B2 to A. Data can go from A to one or both B ports, and from either B port back to A. A 2:1 multiplexer chooses which B-side register drives A. All registers, including a small control register, share one clock.

The A output enable, the shared B output enable and the multiplexer select are each captured on a clock edge. A change of direction or source therefore takes effect only at the next edge. Each bidirectional port is modelled as three signals: an input word with a drive-valid flag, an output word, and an output-enable flag.

A keeper on each port input remembers the last value that was validly driven while the port was released. The loading registers therefore always see a defined word. Reset is synchronous and active high.

Top module: `bus_exchanger`

## Requirements
- R1: While `rst` is high at a clock edge, every data register, every keeper and the select are cleared to zero, and both output enables are cleared to 0 (released). So after that edge `a_out`, `b1_out` and `b2_out` are 0 and `a_oe`, `b_oe` are 0.
- R2: At an edge where `ld_a_b1_n` is 0, the A-to-B1 register takes the A-side view, which is then visible on `b1_out` after the edge. At an edge where `ld_a_b1_n` is 1, `b1_out` keeps its value.
- R3: At an edge where `ld_a_b2_n` is 0, the A-to-B2 register takes the A-side view onto `b2_out`. At an edge where `ld_a_b2_n` is 1, `b2_out` keeps its value.
- R4: At an edge where `ld_b1_a_n` (or `ld_b2_a_n`) is 0, the B1-to-A (or B2-to-A) register takes the B1 (or B2) side view.
- R5: `a_out` shows the B1-to-A register while the registered select is 0, and the B2-to-A register while it is 1. The select input `sel` is sampled only at clock edges, so changing it between edges leaves `a_out` unchanged.
- R6: `a_oe` becomes the inverse of `oe_a_n`, and `b_oe` the inverse of `oe_b_n`, one edge after sampling. Between edges neither output enable changes.
- R7: The side view of a port is its input word when the port is released (its output enable is 0) and its valid flag is 1. Otherwise the side view is the keeper's value. The keeper takes the input word only in the first case.
- R8: While a port's registered output enable is 1, its input word and valid flag have no effect on its keeper.
- R9: When an A-to-B load and a B-to-A load fall on the same edge, each register takes the side view present before that edge. A select change and a load of the newly selected register on the same edge show the new word on `a_out` right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 12 | Word driven onto port A from outside |
| a_vld | input | 1 | Port A is being driven from outside |
| b1_in | input | 12 | Word driven onto port B1 from outside |
| b2_in | input | 12 | Word driven onto port B2 from outside |
| b_vld | input | 1 | Ports B1 and B2 are being driven from outside |
| ld_a_b1_n | input | 1 | Load A-to-B1 register, active low |
| ld_a_b2_n | input | 1 | Load A-to-B2 register, active low |
| ld_b1_a_n | input | 1 | Load B1-to-A register, active low |
| ld_b2_a_n | input | 1 | Load B2-to-A register, active low |
| oe_a_n | input | 1 | Requested A output enable, active low |
| oe_b_n | input | 1 | Requested shared B output enable, active low |
| sel | input | 1 | Requested A source: 0 selects B1-to-A, 1 selects B2-to-A |
| a_out | output | 12 | Word driven on port A |
| a_oe | output | 1 | Registered A output enable |
| b1_out | output | 12 | Word driven on port B1 |
| b2_out | output | 12 | Word driven on port B2 |
| b_oe | output | 1 | Registered shared B output enable |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a transfer in each direction at once: A-to-B1 and B1-to-A strobes are both low on one edge, with fresh valid words on both sides. Each register must hold the other side's word before that edge. The second pair is a change of the select together with a load of the register it now points at. After that single edge, `a_out` must show the just-loaded word and not the stale contents. Each case is provoked by one directed task, and the outputs are read one time unit after the edge.

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         a_vld,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  input  logic         b_vld,
  input  logic         ld_a_b1_n,
  input  logic         ld_a_b2_n,
  input  logic         ld_b1_a_n,
  input  logic         ld_b2_a_n,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic         sel,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b1_out,
  output logic [W-1:0] b2_out,
  output logic         b_oe
);

  logic         oe_a_q, oe_b_q, sel_q;
  logic [W-1:0] keep_a, keep_b1, keep_b2;
  logic [W-1:0] r_ab1, r_ab2, r_b1a, r_b2a;
  logic         take_a, take_b;
  logic [W-1:0] view_a, view_b1, view_b2;

  assign take_a  = !oe_a_q && a_vld;
  assign take_b  = !oe_b_q && b_vld;
  assign view_a  = take_a ? a_in  : keep_a;
  assign view_b1 = take_b ? b1_in : keep_b1;
  assign view_b2 = take_b ? b2_in : keep_b2;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_a_q <= 1'b0;
      oe_b_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      oe_a_q <= !oe_a_n;
      oe_b_q <= !oe_b_n;
      sel_q  <= sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      keep_a  <= '0;
      keep_b1 <= '0;
      keep_b2 <= '0;
    end else begin
      if (take_a) keep_a <= a_in;
      if (take_b) begin
        keep_b1 <= b1_in;
        keep_b2 <= b2_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_ab1 <= '0;
      r_ab2 <= '0;
      r_b1a <= '0;
      r_b2a <= '0;
    end else begin
      if (!ld_a_b1_n) r_ab1 <= view_a;
      if (!ld_a_b2_n) r_ab2 <= view_a;
      if (!ld_b1_a_n) r_b1a <= view_b1;
      if (!ld_b2_a_n) r_b2a <= view_b2;
    end
  end

  assign a_out  = sel_q ? r_b2a : r_b1a;
  assign a_oe   = oe_a_q;
  assign b1_out = r_ab1;
  assign b2_out = r_ab2;
  assign b_oe   = oe_b_q;

endmodule

module bus_exchanger_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         ld_a_b1_n,
  input logic         ld_a_b2_n,
  input logic         ld_b1_a_n,
  input logic         ld_b2_a_n,
  input logic         oe_a_n,
  input logic         oe_b_n,
  input logic         sel,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b1_out,
  input logic [W-1:0] b2_out,
  input logic         b_oe,
  input logic [W-1:0] keep_a,
  input logic [W-1:0] keep_b1,
  input logic [W-1:0] keep_b2
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!a_oe && !b_oe && a_out == '0 && b1_out == '0 && b2_out == '0)); // R1

  AST_B1_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ld_a_b1_n |=> $stable(b1_out)); // R2

  AST_B2_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ld_a_b2_n |=> $stable(b2_out)); // R3

  AST_A_SOURCE_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ld_b1_a_n && ld_b2_a_n && sel == $past(sel)) |=> $stable(a_out)); // R5

  AST_OE_A_REGISTERED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> a_oe == !$past(oe_a_n)); // R6

  AST_OE_B_REGISTERED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> b_oe == !$past(oe_b_n)); // R6

  AST_KEEP_A_FROZEN: assert property (@(posedge clk) disable iff (rst)
    a_oe |=> keep_a == $past(keep_a)); // R8

  AST_KEEP_B_FROZEN: assert property (@(posedge clk) disable iff (rst)
    b_oe |=> (keep_b1 == $past(keep_b1) && keep_b2 == $past(keep_b2))); // R8

endmodule

bind bus_exchanger bus_exchanger_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst),
  .ld_a_b1_n(ld_a_b1_n), .ld_a_b2_n(ld_a_b2_n),
  .ld_b1_a_n(ld_b1_a_n), .ld_b2_a_n(ld_b2_a_n),
  .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .sel(sel),
  .a_out(a_out), .a_oe(a_oe), .b1_out(b1_out), .b2_out(b2_out), .b_oe(b_oe),
  .keep_a(keep_a), .keep_b1(keep_b1), .keep_b2(keep_b2)
);

// File: tb/bus_exchanger_tb.sv
module bus_exchanger_tb;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic a_vld = 1'b0, b_vld = 1'b0;
  logic ld_a_b1_n = 1'b1, ld_a_b2_n = 1'b1, ld_b1_a_n = 1'b1, ld_b2_a_n = 1'b1;
  logic oe_a_n = 1'b1, oe_b_n = 1'b1, sel = 1'b0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_oe, b_oe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_exchanger #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .a_vld(a_vld),
    .b1_in(b1_in), .b2_in(b2_in), .b_vld(b_vld),
    .ld_a_b1_n(ld_a_b1_n), .ld_a_b2_n(ld_a_b2_n),
    .ld_b1_a_n(ld_b1_a_n), .ld_b2_a_n(ld_b2_a_n),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .sel(sel),
    .a_out(a_out), .a_oe(a_oe), .b1_out(b1_out), .b2_out(b2_out), .b_oe(b_oe)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    a_vld = 1'b0; b_vld = 1'b0;
    ld_a_b1_n = 1'b1; ld_a_b2_n = 1'b1; ld_b1_a_n = 1'b1; ld_b2_a_n = 1'b1;
  endtask

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step();
    check("R1 a_out", a_out, '0);
    check("R1 b1_out", b1_out, '0);
    check("R1 b2_out", b2_out, '0);
    check("R1 oe", {10'd0, a_oe, b_oe}, '0);
    rst = 1'b0;
  endtask

  task automatic t_a_to_b();
    a_vld = 1'b1; a_in = 12'hABC; ld_a_b1_n = 1'b0; step();
    check("R2 load", b1_out, 12'hABC);
    check("R3 hold", b2_out, 12'h000);
    ld_a_b1_n = 1'b1; ld_a_b2_n = 1'b0; a_in = 12'h123; step();
    check("R3 load", b2_out, 12'h123);
    check("R2 hold", b1_out, 12'hABC);
    idle();
  endtask

  task automatic t_b_to_a();
    b_vld = 1'b1; b1_in = 12'h5A5; b2_in = 12'hA5A;
    ld_b1_a_n = 1'b0; ld_b2_a_n = 1'b0; sel = 1'b0; step();
    check("R4 b1 to a", a_out, 12'h5A5);
    idle();
    sel = 1'b1; #1;
    check("R5 no change before edge", a_out, 12'h5A5);
    step();
    check("R4 R5 b2 to a", a_out, 12'hA5A);
  endtask

  task automatic t_oe();
    oe_a_n = 1'b0; #1;
    check("R6 a_oe before edge", {11'd0, a_oe}, 12'd0);
    step();
    check("R6 a_oe", {11'd0, a_oe}, 12'd1);
    oe_b_n = 1'b0; oe_a_n = 1'b1; step();
    check("R6 b_oe", {10'd0, a_oe, b_oe}, 12'd1);
    oe_b_n = 1'b1; step();
    check("R6 release", {10'd0, a_oe, b_oe}, 12'd0);
  endtask

  task automatic t_keeper();
    a_vld = 1'b1; a_in = 12'h3C3; step();
    a_vld = 1'b0; a_in = 12'hFFF; ld_a_b1_n = 1'b0; step();
    check("R7 held word loaded", b1_out, 12'h3C3);
    idle();
  endtask

  task automatic t_keeper_driving();
    oe_a_n = 1'b0; step();
    a_vld = 1'b1; a_in = 12'h111; step();
    oe_a_n = 1'b1; a_vld = 1'b0; step();
    ld_a_b1_n = 1'b0; step();
    check("R8 keeper ignores input while driving", b1_out, 12'h3C3);
    idle();
    oe_b_n = 1'b0; step();
    b_vld = 1'b1; b1_in = 12'h777; step();
    oe_b_n = 1'b1; b_vld = 1'b0; step();
    sel = 1'b0; ld_b1_a_n = 1'b0; step();
    check("R8 B keeper ignores input while driving", a_out, 12'h5A5);
    idle();
  endtask

  task automatic t_exchange();
    a_vld = 1'b1; a_in = 12'h0F0; b_vld = 1'b1; b1_in = 12'h70F;
    ld_a_b1_n = 1'b0; ld_b1_a_n = 1'b0; sel = 1'b0; step();
    check("R9 exchange to b1", b1_out, 12'h0F0);
    check("R9 exchange to a", a_out, 12'h70F);
    idle();
    b_vld = 1'b1; b2_in = 12'h246; ld_b2_a_n = 1'b0; sel = 1'b1; step();
    check("R9 select with load", a_out, 12'h246);
    idle();
  endtask

  initial begin
    t_reset();
    t_a_to_b();
    t_b_to_a();
    t_oe();
    t_keeper();
    t_keeper_driving();
    t_exchange();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule